// File: doc/BRIEF.md
# Line Sensor Readout Sequencer

This block is the master that runs a 256-pixel line-scan sensor built from two sections of 128 pixels. It divides the system clock into a free-running sensor clock. It launches each frame with a start pulse that covers exactly one sensor clock rising edge. For every pixel it produces a one-cycle sample strobe, which tells the downstream converter when to capture and which pixel index (or pair of indices) it holds.

The block handles both ways of wiring the sensor. In serial wiring the two sections read out one after the other: 256 pixel clocks and then one clock that ends the output. In parallel wiring both section outputs are valid at once: 128 pixel clocks and then one terminating clock.

Integration of the next frame begins on the 19th rising edge of the current readout. The block counts the programmed integration time from that edge and holds off the next start pulse until the time has elapsed. A request that is too short is lengthened to a safe value, and a status bit reports when that happened. While `run` is high, frames follow one another at that spacing.

Top module: `lss_readout_seq`

## Requirements
- R1: The sensor clock runs freely after reset. Each of its high and low phases lasts `cfg_half_div` system clocks, and a value of 0 is treated as 1.
- R2: Counted from the rising edge that samples the start pulse high (edge 1), a frame has 257 sensor clock rising edges in serial wiring (`cfg_parallel`=0) and 129 in parallel wiring (`cfg_parallel`=1).
- R3: `sen_si` changes only in the cycle where the sensor clock falls. Each start pulse covers exactly one sensor clock rising edge.
- R4: `busy` rises together with `sen_si` and clears at the terminating rising edge of the frame. `frame_done` is high for one system cycle, at exactly that moment and at no other time.
- R5: A frame starts only while `run` is high. Once `run` is low, the frame in progress completes and no further frame starts.
- R6: `pix_strobe` is a one-cycle pulse that appears STROBE_LAG system clocks after each of the first N rising edges of a frame, with edge k carrying pixel k-1. In serial wiring N=256, `pix_idx_a` runs from 0 to 255, `pix_idx_b`=0 and `pix_dual`=0. In parallel wiring N=128, `pix_idx_a` runs from 0 to 127, `pix_idx_b`=`pix_idx_a`+128 and `pix_dual`=1.
- R7: Between frames that run back to back, the number of sensor clock rising edges from edge 19 of one frame to edge 1 of the next equals the effective integration time.
- R8: RD is 239 in serial wiring and 111 in parallel wiring. MIN is 272 in serial wiring and 144 in parallel wiring. If `cfg_int_clks` is below RD or below MIN, the effective time is RD+MIN and `int_extended` is 1. Otherwise the effective time is `cfg_int_clks` and `int_extended` is 0. `int_extended` is updated at edge 19 of each frame.
- R9: The wiring mode and the integration request are captured when the start pulse rises. Changing them during a frame has no effect on that frame's strobes, its length or its `int_extended`.
- R10: During reset and directly after it, `sen_si`, `busy`, `frame_done`, `pix_strobe` and `int_extended` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep scanning while high |
| cfg_parallel | input | 1 | 0 = serial wiring, 1 = parallel wiring |
| cfg_half_div | input | DIV_W | Sensor clock half period in system clocks |
| cfg_int_clks | input | INT_W | Requested integration time in sensor clocks |
| sen_clk | output | 1 | Sensor clock |
| sen_si | output | 1 | Sensor start pulse |
| pix_strobe | output | 1 | Converter sample strobe |
| pix_idx_a | output | IDX_W | Pixel index of section output 1 (or of the only output) |
| pix_idx_b | output | IDX_W | Pixel index of section output 2 in parallel wiring |
| pix_dual | output | 1 | Both indices valid |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| int_extended | output | 1 | Integration request was lengthened |

## Verification
The hardest situation to reach is a change of configuration in the middle of a frame. The new values must not leak into the strobes, the frame length or the extension flag. To get there, the stimulus starts a parallel frame with a long request and then, the moment `busy` rises, switches the wiring to serial and sets the request to 1. The edge counts, the strobe stream and `int_extended` must still match the values captured at the start.

The integration boundary is reached by several back-to-back runs. One request sits exactly at the serial minimum, one sits one below it, and one parallel request sits below the minimum. In each case the rising edges from edge 19 to the next start are counted.

// File: rtl/lss_pkg.sv
// Shared types and constants for the line sensor readout sequencer.
package lss_pkg;
    // How the two sensor sections are wired to the converter
    typedef enum logic {
        WIRE_SERIAL   = 1'b0,
        WIRE_PARALLEL = 1'b1
    } wiring_e;

    // Readout edge on which the sensor begins the next integration
    localparam int INT_START_EDGE = 19;
    // Number of readout edges spent resetting the integrators
    localparam int RESET_EDGES    = 18;
endpackage

// File: rtl/lss_clkgen.sv
// Sensor clock divider.
// Toggles the sensor clock every cfg_half_div system clocks (0 acts as 1).
// It flags in advance the system cycle whose closing edge raises or lowers
// the sensor clock, so the sequencer can act on that same edge.
// Assumes the configuration is held steady while timing matters.
module lss_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_half_div,
    output logic             sclk,
    output logic             rise_now,
    output logic             fall_now
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_eff;
    logic             tick;

    // Clamp a zero half period to one system clock
    always_comb begin
        half_eff = (cfg_half_div == '0) ? DIV_W'(1) : cfg_half_div;
        tick     = (cnt_q >= half_eff - DIV_W'(1));
        rise_now = tick && !sclk;
        fall_now = tick && sclk;
    end

    // Count the half period and toggle the sensor clock when it ends
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (tick) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/lss_frame_ctl.sv
// Frame sequencer.
// Raises the start pulse on a falling sensor clock once the integration gap
// has run out, counts the readout edges, ends the frame on the terminating
// edge and loads the integration gap at the integration-start edge.
// It produces an unregistered strobe request on each pixel edge.
// Assumes SEC_PIX >= RESET_EDGES so that the integration-start edge lies
// inside every frame.
module lss_frame_ctl
    import lss_pkg::*;
#(
    parameter int SEC_PIX     = 128,
    parameter int INT_W       = 20,
    parameter int MIN_INT_SER = 272,
    parameter int MIN_INT_PAR = 144
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rise_now,
    input  logic                              fall_now,
    input  logic                              run,
    input  logic                              cfg_parallel,
    input  logic [INT_W-1:0]                  cfg_int,
    output logic                              si,
    output logic                              busy,
    output logic                              done,
    output logic                              ext,
    output logic                              stb_req,
    output logic [$clog2(2*SEC_PIX)-1:0]      idx_req,
    output logic                              par_req
);
    localparam int TOT_SER = 2 * SEC_PIX + 1;
    localparam int TOT_PAR = SEC_PIX + 1;
    localparam int RD_SER  = TOT_SER - RESET_EDGES;
    localparam int RD_PAR  = TOT_PAR - RESET_EDGES;
    localparam int EDGE_W  = $clog2(TOT_SER + 1);
    localparam int IDX_W   = $clog2(2 * SEC_PIX);

    wiring_e          par_q;
    logic [INT_W-1:0] req_q;
    logic [EDGE_W-1:0] edge_cnt;
    logic [EDGE_W-1:0] edge_nxt;
    logic [EDGE_W-1:0] tot_cur;
    logic [EDGE_W-1:0] npix_cur;
    logic [INT_W-1:0] gap_cnt;
    logic [INT_W-1:0] rd_cur;
    logic [INT_W-1:0] min_cur;
    logic [INT_W-1:0] eff_int;
    logic             ext_calc;

    // Per-mode limits and the effective integration time
    always_comb begin
        edge_nxt = edge_cnt + EDGE_W'(1);
        if (par_q == WIRE_PARALLEL) begin
            tot_cur  = EDGE_W'(TOT_PAR);
            npix_cur = EDGE_W'(SEC_PIX);
            rd_cur   = INT_W'(RD_PAR);
            min_cur  = INT_W'(MIN_INT_PAR);
        end else begin
            tot_cur  = EDGE_W'(TOT_SER);
            npix_cur = EDGE_W'(2 * SEC_PIX);
            rd_cur   = INT_W'(RD_SER);
            min_cur  = INT_W'(MIN_INT_SER);
        end
        ext_calc = (req_q < rd_cur) || (req_q < min_cur);
        eff_int  = ext_calc ? (rd_cur + min_cur) : req_q;
    end

    // Strobe request on each pixel edge; edge k carries pixel k-1
    always_comb begin
        stb_req = rise_now && (si || (busy && (edge_nxt <= npix_cur)));
        idx_req = si ? '0 : edge_cnt[IDX_W-1:0];
        par_req = (par_q == WIRE_PARALLEL);
    end

    // Start pulse, frame edge counting, end of frame and status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si       <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            ext      <= 1'b0;
            par_q    <= WIRE_SERIAL;
            req_q    <= '0;
            edge_cnt <= '0;
        end else begin
            done <= 1'b0;
            if (fall_now) begin
                if (si) begin
                    si <= 1'b0;
                end else if (!busy && run && (gap_cnt <= INT_W'(1))) begin
                    si    <= 1'b1;
                    busy  <= 1'b1;
                    par_q <= wiring_e'(cfg_parallel);
                    req_q <= cfg_int;
                end
            end
            if (rise_now) begin
                if (si) begin
                    edge_cnt <= EDGE_W'(1);
                end else if (busy) begin
                    edge_cnt <= edge_nxt;
                    if (edge_nxt == EDGE_W'(INT_START_EDGE)) begin
                        ext <= ext_calc;
                    end
                    if (edge_nxt == tot_cur) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    // Integration gap: loaded at the integration-start edge, counted down per edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (rise_now) begin
            if (busy && !si && (edge_nxt == EDGE_W'(INT_START_EDGE))) begin
                gap_cnt <= eff_int;
            end else if (gap_cnt != '0) begin
                gap_cnt <= gap_cnt - INT_W'(1);
            end
        end
    end

    // R4: the start pulse only ever sits inside a busy frame
    p_si_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        si |-> busy);

    // R4: the done pulse marks the busy flag falling
    p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R6: pixel strobes are requested only inside a frame
    p_strobe_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_req |-> busy);

    // R2: the edge count never reaches past the terminating edge
    p_edge_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !si) |-> (edge_cnt < tot_cur));
endmodule

// File: rtl/lss_strobe_pipe.sv
// Strobe delay line.
// Delays the strobe request, pixel index and mode by STROBE_LAG system
// clocks, then forms the second index used in parallel wiring.
// Assumes STROBE_LAG >= 1.
module lss_strobe_pipe #(
    parameter int SEC_PIX    = 128,
    parameter int STROBE_LAG = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         stb_in,
    input  logic [$clog2(2*SEC_PIX)-1:0] idx_in,
    input  logic                         par_in,
    output logic                         pix_strobe,
    output logic [$clog2(2*SEC_PIX)-1:0] pix_idx_a,
    output logic [$clog2(2*SEC_PIX)-1:0] pix_idx_b,
    output logic                         pix_dual
);
    localparam int IDX_W = $clog2(2 * SEC_PIX);

    logic             v_chain [STROBE_LAG+1];
    logic             p_chain [STROBE_LAG+1];
    logic [IDX_W-1:0] i_chain [STROBE_LAG+1];

    assign v_chain[0] = stb_in;
    assign p_chain[0] = par_in;
    assign i_chain[0] = idx_in;

    for (genvar g = 0; g < STROBE_LAG; g++) begin : g_stage
        // One delay stage of the strobe, its index and its mode
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_chain[g+1] <= 1'b0;
                p_chain[g+1] <= 1'b0;
                i_chain[g+1] <= '0;
            end else begin
                v_chain[g+1] <= v_chain[g];
                p_chain[g+1] <= p_chain[g];
                i_chain[g+1] <= i_chain[g];
            end
        end
    end

    // Output stage: the second section's index exists only in parallel wiring
    always_comb begin
        pix_strobe = v_chain[STROBE_LAG];
        pix_dual   = p_chain[STROBE_LAG];
        pix_idx_a  = i_chain[STROBE_LAG];
        pix_idx_b  = pix_dual ? (i_chain[STROBE_LAG] + IDX_W'(SEC_PIX)) : '0;
    end

    // R6: a strobe lasts one cycle (sensor period is at least two cycles)
    p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_strobe |=> !pix_strobe);
endmodule

// File: rtl/lss_readout_seq.sv
// Line sensor readout sequencer, top level.
// Joins the clock divider, the frame sequencer and the strobe delay line.
// Assumes a two-section sensor of SEC_PIX pixels per section, wired either
// serially or in parallel as selected by cfg_parallel at each frame start.
module lss_readout_seq #(
    parameter int SEC_PIX     = 128,
    parameter int DIV_W       = 16,
    parameter int INT_W       = 20,
    parameter int MIN_INT_SER = 272,
    parameter int MIN_INT_PAR = 144,
    parameter int STROBE_LAG  = 2,
    localparam int IDX_W      = $clog2(2 * SEC_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_parallel,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic [INT_W-1:0] cfg_int_clks,
    output logic             sen_clk,
    output logic             sen_si,
    output logic             pix_strobe,
    output logic [IDX_W-1:0] pix_idx_a,
    output logic [IDX_W-1:0] pix_idx_b,
    output logic             pix_dual,
    output logic             busy,
    output logic             frame_done,
    output logic             int_extended
);
    logic             rise_now;
    logic             fall_now;
    logic             stb_req;
    logic [IDX_W-1:0] idx_req;
    logic             par_req;

    lss_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_half_div (cfg_half_div),
        .sclk         (sen_clk),
        .rise_now     (rise_now),
        .fall_now     (fall_now)
    );

    lss_frame_ctl #(
        .SEC_PIX     (SEC_PIX),
        .INT_W       (INT_W),
        .MIN_INT_SER (MIN_INT_SER),
        .MIN_INT_PAR (MIN_INT_PAR)
    ) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .rise_now     (rise_now),
        .fall_now     (fall_now),
        .run          (run),
        .cfg_parallel (cfg_parallel),
        .cfg_int      (cfg_int_clks),
        .si           (sen_si),
        .busy         (busy),
        .done         (frame_done),
        .ext          (int_extended),
        .stb_req      (stb_req),
        .idx_req      (idx_req),
        .par_req      (par_req)
    );

    lss_strobe_pipe #(
        .SEC_PIX    (SEC_PIX),
        .STROBE_LAG (STROBE_LAG)
    ) u_pipe (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb_in     (stb_req),
        .idx_in     (idx_req),
        .par_in     (par_req),
        .pix_strobe (pix_strobe),
        .pix_idx_a  (pix_idx_a),
        .pix_idx_b  (pix_idx_b),
        .pix_dual   (pix_dual)
    );

    // R3: the start pulse moves only while the sensor clock falls
    p_si_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sen_si != $past(sen_si)) |-> $fell(sen_clk));
endmodule

// File: tb/lss_readout_seq_tb.sv
module lss_readout_seq_tb;
    localparam int SEC     = 128;
    localparam int LAG     = 2;
    localparam int MIN_SER = 272;
    localparam int MIN_PAR = 144;
    localparam int RSTE    = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cfg_parallel = 1'b0;
    logic [15:0] cfg_half_div = 16'd1;
    logic [19:0] cfg_int_clks = 20'd0;
    logic        sen_clk, sen_si, pix_strobe, pix_dual, busy, frame_done, int_extended;
    logic [7:0]  pix_idx_a, pix_idx_b;

    always #2.5 clk = ~clk;

    lss_readout_seq u_dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_parallel(cfg_parallel),
        .cfg_half_div(cfg_half_div), .cfg_int_clks(cfg_int_clks),
        .sen_clk(sen_clk), .sen_si(sen_si), .pix_strobe(pix_strobe),
        .pix_idx_a(pix_idx_a), .pix_idx_b(pix_idx_b), .pix_dual(pix_dual),
        .busy(busy), .frame_done(frame_done), .int_extended(int_extended)
    );

    typedef struct { int a; int b; bit dual; } stb_t;
    typedef struct { int total; int gap; bit chk; } frm_t;
    stb_t stb_q[$];
    frm_t frm_q[$];
    frm_t cur;

    int checks = 0;
    int fails = 0;
    int gr = 0, g19 = 0, ek = 0, since = 0, si_rises = 0;
    int busy_rises = 0, frames_done = 0;
    bit in_frame = 0;
    logic sclk_prev = 0, si_prev = 0, busy_prev = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: follows the sensor clock and pops expected items as results appear
    always @(negedge clk) begin
        if (!rst_n) begin
            sclk_prev = 0; si_prev = 0; busy_prev = 0; in_frame = 0;
        end else begin
            if (sen_si != si_prev)
                check(sclk_prev && !sen_clk, "R3", "SI moved off a falling clock", int'(sen_clk), 0);
            if (sen_clk && !sclk_prev) begin
                gr++;
                since = 0;
                if (sen_si) begin
                    si_rises++;
                    if (frm_q.size() == 0) begin
                        check(0, "R5", "unexpected frame start", 1, 0);
                        cur = '{0, 0, 0};
                    end else begin
                        cur = frm_q.pop_front();
                        if (cur.chk) check(gr - g19 == cur.gap, "R7", "integration edges", gr - g19, cur.gap);
                    end
                    ek = 1;
                    in_frame = 1;
                end else if (in_frame) begin
                    ek++;
                end
                if (in_frame && ek == RSTE + 1) g19 = gr;
            end else begin
                since++;
            end
            if (!sen_si && si_prev) begin
                check(si_rises == 1, "R3", "rising edges under SI", si_rises, 1);
                si_rises = 0;
            end
            if (busy && !busy_prev) begin
                busy_rises++;
                check(sen_si, "R4", "busy rises with SI", int'(sen_si), 1);
            end
            if (!busy && busy_prev) begin
                check(in_frame && ek == cur.total, "R2", "edges per frame", ek, cur.total);
                check(frame_done, "R4", "frame_done at busy clear", int'(frame_done), 1);
                frames_done++;
                in_frame = 0;
            end else if (frame_done) begin
                check(0, "R4", "stray frame_done", 1, 0);
            end
            if (pix_strobe) begin
                if (stb_q.size() == 0) begin
                    check(0, "R6", "unexpected strobe", int'(pix_idx_a), -1);
                end else begin
                    stb_t e;
                    e = stb_q.pop_front();
                    check(int'(pix_idx_a) == e.a, "R6", "index a", int'(pix_idx_a), e.a);
                    check(int'(pix_idx_b) == e.b, "R6", "index b", int'(pix_idx_b), e.b);
                    check(pix_dual == e.dual, "R6", "dual flag", int'(pix_dual), int'(e.dual));
                end
                check(since == LAG - 1, "R6", "strobe lag", since, LAG - 1);
            end
            sclk_prev = sen_clk; si_prev = sen_si; busy_prev = busy;
        end
    end

    task automatic wait_rise();
        logic p;
        p = sen_clk;
        forever begin
            @(negedge clk);
            if (sen_clk && !p) break;
            p = sen_clk;
        end
    endtask

    // R1: measure one high and one low phase of the sensor clock
    task automatic check_period(int half);
        int hi, lo;
        wait_rise();
        wait_rise();
        hi = 1;
        forever begin @(negedge clk); if (sen_clk) hi++; else break; end
        lo = 1;
        forever begin @(negedge clk); if (!sen_clk) lo++; else break; end
        check(hi == half, "R1", "high phase", hi, half);
        check(lo == half, "R1", "low phase", lo, half);
    endtask

    // Driver: push the expected frames and strobes, then run n frames
    task automatic run_frames(bit par, int half, int req, int n, bit perturb);
        int tot, npx, rd, mn, eff, base_b, base_d;
        bit ext;
        tot = par ? SEC + 1 : 2 * SEC + 1;
        npx = par ? SEC : 2 * SEC;
        rd  = tot - RSTE;
        mn  = par ? MIN_PAR : MIN_SER;
        ext = (req < rd) || (req < mn);
        eff = ext ? rd + mn : req;
        @(negedge clk);
        cfg_parallel = par;
        cfg_half_div = 16'(half);
        cfg_int_clks = 20'(req);
        check_period(half);
        for (int f = 0; f < n; f++) begin
            frm_q.push_back('{tot, eff, f > 0});
            for (int k = 0; k < npx; k++) stb_q.push_back('{k, par ? k + SEC : 0, par});
        end
        base_b = busy_rises;
        base_d = frames_done;
        run = 1'b1;
        while (busy_rises < base_b + n) @(negedge clk);
        if (perturb) begin
            cfg_parallel = !par;   // R9: must not affect the running frame
            cfg_int_clks = 20'd1;
        end
        run = 1'b0;
        while (frames_done < base_d + n) @(negedge clk);
        check(int_extended == ext, "R8", "int_extended", int'(int_extended), int'(ext));
        repeat (eff * 2 * half + 200) @(negedge clk);
        check(busy_rises == base_b + n, "R5", "frames after run low", busy_rises - base_b, n);
        check(stb_q.size() == 0, "R6", "strobes left over", stb_q.size(), 0);
        check(frm_q.size() == 0, "R2", "frames left over", frm_q.size(), 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        check(!sen_si && !busy && !frame_done && !pix_strobe && !int_extended,
              "R10", "outputs in reset", int'(sen_si | busy | pix_strobe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sen_si && !busy && !int_extended, "R10", "outputs after reset", int'(busy), 0);
        repeat (100) @(negedge clk);
        check(busy_rises == 0, "R5", "no frame while run low", busy_rises, 0);
        run_frames(1'b0, 2, 10, 2, 1'b0);    // serial, short request: R8 extension
        run_frames(1'b1, 1, 300, 3, 1'b0);   // parallel, plain request
        run_frames(1'b0, 1, 272, 2, 1'b0);   // serial, exactly at the minimum
        run_frames(1'b0, 1, 271, 2, 1'b0);   // serial, one below: extended
        run_frames(1'b1, 3, 143, 2, 1'b0);   // parallel, below the minimum
        run_frames(1'b1, 1, 300, 1, 1'b1);   // R9: config changed mid-frame
        cfg_half_div = 16'd0;                // R1: zero acts as one
        check_period(1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog R2: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule